// File: doc/BRIEF.md
# Deglitched Interrupt Combiner

This block gathers the interrupt requests of four downstream bus segments into one shared interrupt line for an upstream host. Each request arrives as an active-low level. Each level is first brought into the local clock domain through two flops. It then passes through its own digital deglitch filter, which ignores short excursions. A filtered request has to stay low for a longer window before it is accepted. A filtered clear only has to stay high for a shorter window. The combined line is asserted when any filtered request is active. The block drives it as an enable for an external open-drain pull-down.

The filtered levels are also offered to the register logic as a four-bit status vector. This vector is captured only when a read of the control register takes place, signalled by a one-cycle read strobe. Bit n of the captured vector reads 1 when channel n has an interrupt pending. Detection does not depend on which channels the switch currently connects, so the block has no channel-select input.

The filter windows are counted in ticks from a prescaler. The counts and the prescale ratio are parameters. The defaults give about 1 µs of low-pulse rejection and 0.5 µs of high-pulse rejection with a 50 MHz clock.

Top module: `chan_irq_combiner`

## Requirements
- R1: During and after reset, every filtered level is inactive (high), `irqOutEn` is 0 and `statusBits` is 0. The raw inputs reach the filters through a two-flop synchronizer whose flops reset to high.
- R2: `irqOutEn` is a register. It is 1 (pull the shared line low) in the cycle after any filtered level is low. It is 0 in the cycle after all filtered levels are high.
- R3: A low pulse on a raw input that lasts at most (LOW_TICKS-1)*TICK_DIV clock cycles leaves the filtered level and `irqOutEn` unchanged. A low level held on an input that was high asserts `irqOutEn` within LOW_TICKS*TICK_DIV+4 cycles.
- R4: While a channel is filtered low, a high pulse of at most (HIGH_TICKS-1)*TICK_DIV cycles is ignored. A high level held on every channel releases `irqOutEn` within HIGH_TICKS*TICK_DIV+4 cycles.
- R5: A filtered level changes only on a cycle in which the prescaler tick is present. The tick occurs once every TICK_DIV cycles. As a result, `irqOutEn` is still 0 at least (LOW_TICKS-1)*TICK_DIV+2 cycles after a raw input falls.
- R6: A one-cycle `rdStrobe` loads `statusBits`, and the value is visible in the following cycle. Bit n becomes 1 when channel n's filtered level is low at the strobe edge and 0 when it is high.
- R7: Without `rdStrobe`, `statusBits` keeps its value whatever the raw inputs do.
- R8: The four channels are filtered independently. Any single channel alone asserts `irqOutEn` and reports only its own status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rawIrqN | input | NUM_CH | Raw active-low interrupt requests, bit n for channel n |
| rdStrobe | input | 1 | One-cycle pulse when the control register is read |
| irqOutEn | output | 1 | 1 enables the open-drain pull-down of the shared interrupt line |
| statusBits | output | NUM_CH | Captured interrupt flags, bit n = 1 when channel n is pending |

## Verification
Directed pulses just inside each rejection window, and levels held just beyond it, are applied in both directions. These show that the low-going and high-going windows are separate, and that the boundary lies on the correct side. A minimum-latency probe confirms that acceptance waits for whole ticks, not single clock cycles. Each channel is also driven alone, which shows that one channel cannot set another channel's status bit. Seeded random rounds overlay short glitches on random level patterns and interleave reads with input changes without a read, which separates the live filtered state from the captured status.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Strobes sent from the control side to the datapath each cycle.
  typedef struct packed {
    logic tick;        // prescaled filter time base
    logic loadStatus;  // capture filtered state into the status register
  } irqStrobe_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int TICK_DIV = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdStrobe,
  output irqStrobe_t strobe
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic tickNow;

  generate
    if (TICK_DIV > 1) begin : g_prescale
      localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);
      logic [DIV_W-1:0] divCnt;
      logic             tickReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          divCnt  <= '0;
          tickReg <= 1'b0;
        end else begin
          if (divCnt == LAST) begin
            divCnt  <= '0;
            tickReg <= 1'b1;
          end else begin
            divCnt  <= divCnt + 1'b1;
            tickReg <= 1'b0;
          end
        end
      end
      assign tickNow = tickReg;
    end else begin : g_every_cycle
      assign tickNow = 1'b1;
    end
  endgenerate

  always_comb begin
    strobe.tick       = tickNow;
    strobe.loadStatus = rdStrobe;
  end
endmodule

// File: rtl/irq_filter_cell.sv
module irq_filter_cell #(
  parameter int LOW_TICKS  = 10,
  parameter int HIGH_TICKS = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic syncLvl,
  output logic filtLvl
);
  localparam int MAX_TICKS = (LOW_TICKS > HIGH_TICKS) ? LOW_TICKS : HIGH_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_TICKS - 1);
  localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(HIGH_TICKS - 1);

  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] needLast;
  logic             differs;

  always_comb begin
    differs  = (syncLvl != filtLvl);
    needLast = syncLvl ? HIGH_LAST : LOW_LAST;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt  <= '0;
      filtLvl <= 1'b1;
    end else if (!differs) begin
      runCnt <= '0;
    end else if (tick) begin
      if (runCnt >= needLast) begin
        filtLvl <= syncLvl;
        runCnt  <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int LOW_TICKS  = 10,
  parameter int HIGH_TICKS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] rawIrqN,
  input  irqStrobe_t        strobe,
  output logic [NUM_CH-1:0] filtLvl,
  output logic              irqOutEn,
  output logic [NUM_CH-1:0] statusBits
);
  logic [NUM_CH-1:0] syncA;
  logic [NUM_CH-1:0] syncB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '1;
      syncB <= '1;
    end else begin
      syncA <= rawIrqN;
      syncB <= syncA;
    end
  end

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      irq_filter_cell #(
        .LOW_TICKS (LOW_TICKS),
        .HIGH_TICKS(HIGH_TICKS)
      ) u_cell (
        .clk    (clk),
        .rstN   (rstN),
        .tick   (strobe.tick),
        .syncLvl(syncB[ch]),
        .filtLvl(filtLvl[ch])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOutEn   <= 1'b0;
      statusBits <= '0;
    end else begin
      irqOutEn <= ~(&filtLvl);
      if (strobe.loadStatus) statusBits <= ~filtLvl;
    end
  end
endmodule

// File: rtl/chan_irq_combiner.sv
module chan_irq_combiner
  import irq_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int TICK_DIV   = 5,
  parameter int LOW_TICKS  = 10,
  parameter int HIGH_TICKS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] rawIrqN,
  input  logic              rdStrobe,
  output logic              irqOutEn,
  output logic [NUM_CH-1:0] statusBits
);
  irqStrobe_t        strobe;
  logic [NUM_CH-1:0] filtLvl;

  irq_ctrl #(.TICK_DIV(TICK_DIV)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rdStrobe(rdStrobe),
    .strobe  (strobe)
  );

  irq_datapath #(
    .NUM_CH    (NUM_CH),
    .LOW_TICKS (LOW_TICKS),
    .HIGH_TICKS(HIGH_TICKS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rawIrqN   (rawIrqN),
    .strobe    (strobe),
    .filtLvl   (filtLvl),
    .irqOutEn  (irqOutEn),
    .statusBits(statusBits)
  );
endmodule

// File: rtl/chan_irq_combiner_chk.sv
module chan_irq_combiner_chk #(
  parameter int NUM_CH   = 4,
  parameter int TICK_DIV = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdStrobe,
  input logic              tick,
  input logic [NUM_CH-1:0] filtLvl,
  input logic              irqOutEn,
  input logic [NUM_CH-1:0] statusBits
);
  // R1
  reset_state_chk: assert property (@(posedge clk) $rose(rstN) |-> (filtLvl == '1) && !irqOutEn && (statusBits == '0));

  // R2
  assert_any_chk: assert property (@(posedge clk) disable iff (!rstN) (filtLvl != '1) |=> irqOutEn);

  // R2
  release_all_chk: assert property (@(posedge clk) disable iff (!rstN) (filtLvl == '1) |=> !irqOutEn);

  // R5
  tick_only_chk: assert property (@(posedge clk) disable iff (!rstN) !tick |=> $stable(filtLvl));

  // R6
  status_load_chk: assert property (@(posedge clk) disable iff (!rstN) rdStrobe |=> (statusBits == ~$past(filtLvl)));

  // R7
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN) !rdStrobe |=> $stable(statusBits));

  generate
    if (TICK_DIV > 1) begin : g_tick_gap
      // R5
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN) tick |=> !tick);
    end
  endgenerate
endmodule

bind chan_irq_combiner chan_irq_combiner_chk #(
  .NUM_CH  (NUM_CH),
  .TICK_DIV(TICK_DIV)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rdStrobe  (rdStrobe),
  .tick      (strobe.tick),
  .filtLvl   (filtLvl),
  .irqOutEn  (irqOutEn),
  .statusBits(statusBits)
);

// File: tb/test_chan_irq_combiner.sv
`timescale 1ns/1ps
module test_chan_irq_combiner;
  localparam int NUM_CH     = 4;
  localparam int TICK_DIV   = 5;
  localparam int LOW_TICKS  = 10;
  localparam int HIGH_TICKS = 5;
  localparam int LOW_WIN    = LOW_TICKS * TICK_DIV;
  localparam int HIGH_WIN   = HIGH_TICKS * TICK_DIV;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NUM_CH-1:0] rawIrqN = '1;
  logic              rdStrobe = 1'b0;
  logic              irqOutEn;
  logic [NUM_CH-1:0] statusBits;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  chan_irq_combiner #(
    .NUM_CH(NUM_CH), .TICK_DIV(TICK_DIV),
    .LOW_TICKS(LOW_TICKS), .HIGH_TICKS(HIGH_TICKS)
  ) i_chan_irq_combiner (
    .clk(clk), .rstN(rstN), .rawIrqN(rawIrqN), .rdStrobe(rdStrobe),
    .irqOutEn(irqOutEn), .statusBits(statusBits)
  );

  function automatic logic expOut(input logic [NUM_CH-1:0] lvl);
    return ~(&lvl);
  endfunction

  function automatic logic [NUM_CH-1:0] expStatus(input logic [NUM_CH-1:0] lvl);
    return ~lvl;
  endfunction

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doRead();
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [NUM_CH-1:0] curLvl;
    logic [NUM_CH-1:0] newLvl;
    logic [NUM_CH-1:0] glitch;
    logic [NUM_CH-1:0] lastStat;
    int seed;
    int dur;
    seed = 32'h5eed_1234;
    void'($urandom(seed));

    // R1 reset state
    waitCyc(3);
    chk("R1 out in reset", irqOutEn, 0);
    chk("R1 status in reset", statusBits, 0);
    rstN = 1'b1;
    waitCyc(LOW_WIN + 6);
    chk("R1 out after reset", irqOutEn, 0);
    doRead();
    chk("R1 filtered high after reset", statusBits, 0);

    // R3 low pulse just inside window is rejected
    rawIrqN[0] = 1'b0;
    waitCyc((LOW_TICKS - 1) * TICK_DIV);
    rawIrqN[0] = 1'b1;
    waitCyc(6);
    chk("R3 short low rejected", irqOutEn, 0);
    doRead();
    chk("R3 short low no status", statusBits, 0);

    // R5 earliest acceptance respects tick granularity
    waitCyc(4);
    rawIrqN[0] = 1'b0;
    waitCyc((LOW_TICKS - 1) * TICK_DIV + 2);
    chk("R5 not yet asserted", irqOutEn, 0);
    // R3 held low accepted
    waitCyc(LOW_WIN + 4 - ((LOW_TICKS - 1) * TICK_DIV + 2));
    chk("R3 held low asserts", irqOutEn, 1);
    doRead();
    chk("R6 status ch0", statusBits, 4'b0001);

    // R4 high pulse just inside window is ignored
    rawIrqN[0] = 1'b1;
    waitCyc((HIGH_TICKS - 1) * TICK_DIV);
    rawIrqN[0] = 1'b0;
    waitCyc(6);
    chk("R4 short high rejected", irqOutEn, 1);
    // R4 held high releases
    waitCyc(4);
    rawIrqN[0] = 1'b1;
    waitCyc(HIGH_WIN + 4);
    chk("R4 held high releases", irqOutEn, 0);

    // R7 status keeps old value without a read
    chk("R7 status held", statusBits, 4'b0001);
    doRead();
    chk("R6 status cleared on read", statusBits, 0);

    // R8 each channel alone
    for (int ch = 0; ch < NUM_CH; ch++) begin
      rawIrqN = '1;
      rawIrqN[ch] = 1'b0;
      waitCyc(LOW_WIN + 6);
      chk("R8 single channel asserts", irqOutEn, 1);
      doRead();
      chk("R8 single channel status", statusBits, 32'(1 << ch));
      rawIrqN = '1;
      waitCyc(HIGH_WIN + 6);
      chk("R8 single channel releases", irqOutEn, 0);
    end
    doRead();
    lastStat = statusBits;
    curLvl = '1;

    // Random rounds: glitches over random levels
    for (int it = 0; it < 60; it++) begin
      glitch = NUM_CH'($urandom());
      dur = 1 + int'($urandom() % ((HIGH_TICKS - 1) * TICK_DIV));
      rawIrqN = curLvl ^ glitch;
      waitCyc(dur);
      rawIrqN = curLvl;
      waitCyc(5);
      chk("R3/R4 random glitch ignored", irqOutEn, expOut(curLvl));
      newLvl = NUM_CH'($urandom());
      rawIrqN = newLvl;
      waitCyc(LOW_WIN + 6);
      curLvl = newLvl;
      chk("R2 random combine", irqOutEn, expOut(curLvl));
      if ($urandom() % 2 == 0) begin
        chk("R7 random no read", statusBits, lastStat);
      end else begin
        doRead();
        lastStat = expStatus(curLvl);
        chk("R6 random read", statusBits, lastStat);
      end
    end

    summary();
  end
endmodule